// File: doc/BRIEF.md
# Serial Flash Status and Write-Gate Controller

This block keeps the status byte and the write-enable latch of a small serial flash device. An SPI front end hands it one finished command per chip-select rise. The command arrives as the opcode, the number of serial clocks seen while the select was low, and the first data byte. The block also samples a write-protect pin, which is active low.

For each command the block decides whether to act on it. Write-enable and write-disable commands change the latch. A status write, a page program or an erase is launched only when all of its gates pass. A launched operation raises the write-in-progress bit for a number of clock cycles set by a parameter for each operation type. At the end of that window the write-in-progress bit and the write-enable latch both drop. The status byte is driven at all times so that the front end can shift it out for a status read.

Top module: `sflash_status_ctrl`

## Requirements
- R1: After reset, `status_byte` is 8'h00 and `busy` is 0. A reset applied during a busy window returns both to those values.
- R2: Opcode 8'h06 sets bit 1 of `status_byte`, the write-enable latch. Opcode 8'h04 clears it. Neither opcode checks the clock count.
- R3: The block treats these opcodes as write commands: 8'h01 (status write), 8'h02 (page program), 8'h20 and 8'hD7 (sector erase), 8'hD8 (block erase), and 8'hC7 and 8'h60 (chip erase). A write command that arrives while the latch is 0 has no effect: `launch` stays 0, `busy` stays 0 and `status_byte` does not change.
- R4: A write command whose `cmd_clk_count` is not a multiple of 8 has no effect.
- R5: An accepted status write copies `cmd_wdata` bits 2, 3, 4 and 7 into the same bit positions of `status_byte` (protect bits and status-lock bit). Bits 5 and 6 of `status_byte` always read 0. Bits 0 and 1 never take their value from the data.
- R6: When status bit 7 is 1 and `wp_n` is 0, a status write has no effect. In every other combination of that bit and that pin, the status write is accepted.
- R7: A chip erase is accepted only when `status_byte` bits 4:2 are all 0.
- R8: An accepted command pulses `launch` in the cycle of `cmd_done`. `busy` and status bit 0 are 1 from the next cycle, for exactly T cycles (T_WRSR, T_PROG, T_SECT, T_BLK or T_CHIP, according to the operation). When `busy` falls, the latch falls in the same cycle.
- R9: While `busy` is 1, every command has no effect. Opcode 8'h05 (status read) changes nothing at any time.
- R10: Bit 0 of `status_byte` always equals `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_done | input | 1 | One-cycle strobe at chip-select rise that marks a complete command |
| cmd_opcode | input | 8 | Opcode of the completed command |
| cmd_clk_count | input | CNT_W | Serial clocks counted while the select was low |
| cmd_wdata | input | 8 | First data byte, used by the status write |
| wp_n | input | 1 | Write-protect pin, active low |
| status_byte | output | 8 | Status value: bit 7 lock, bits 4:2 protect, bit 1 latch, bit 0 busy |
| busy | output | 1 | Write in progress |
| launch | output | 1 | Pulses when a write command is accepted |

## Verification
A wrong latch state appears on `status_byte` bit 1 one cycle after the command that caused it. It also appears as a missing `launch` pulse or an unexpected one on the next write command. A busy counter loaded with the wrong value shows up as a busy window on `busy` and bit 0 that is too short or too long. The bench measures that window to the exact cycle for each operation type. Protect or lock bits that fail to update appear in the status byte the cycle after the write, and later as chip erases or status writes that are accepted or refused when they should not be.

// File: rtl/sfsc_pkg.sv
package sfsc_pkg;

   typedef enum logic [3:0] {
      OPK_NONE, OPK_WREN, OPK_WRDI, OPK_RDSR, OPK_WRSR,
      OPK_PROG, OPK_SECT, OPK_BLK,  OPK_CHIP
   } op_kind_e;

   localparam logic [7:0] OPC_WREN   = 8'h06;
   localparam logic [7:0] OPC_WRDI   = 8'h04;
   localparam logic [7:0] OPC_RDSR   = 8'h05;
   localparam logic [7:0] OPC_WRSR   = 8'h01;
   localparam logic [7:0] OPC_PROG   = 8'h02;
   localparam logic [7:0] OPC_SECT   = 8'h20;
   localparam logic [7:0] OPC_SECT_B = 8'hD7;
   localparam logic [7:0] OPC_BLK    = 8'hD8;
   localparam logic [7:0] OPC_CHIP   = 8'hC7;
   localparam logic [7:0] OPC_CHIP_B = 8'h60;

   // bits of the status byte that a status write may change
   localparam logic [7:0] SR_WMASK   = 8'b1001_1100;

endpackage

// File: rtl/sfsc_decode.sv
module sfsc_decode
   import sfsc_pkg::*;
#(
   parameter int CNT_W    = 12,
   parameter bit ALIAS_EN = 1'b1
) (
   input  logic             cmd_done,
   input  logic [7:0]       cmd_opcode,
   input  logic [CNT_W-1:0] cmd_clk_count,
   input  logic             wp_n,
   input  logic             wel,
   input  logic             wip,
   input  logic             srwd,
   input  logic [2:0]       bp,
   output op_kind_e         kind,
   output logic             set_wel,
   output logic             clr_wel,
   output logic             launch,
   output logic             wrsr_load
);

   localparam logic [CNT_W-1:0] BYTE_LSB_MASK = CNT_W'(7);

   logic is_write, byte_ok, sr_ok, chip_ok, live;

   generate
      if (ALIAS_EN) begin : g_alias
         always_comb begin
            unique case (cmd_opcode)
               OPC_WREN:              kind = OPK_WREN;
               OPC_WRDI:              kind = OPK_WRDI;
               OPC_RDSR:              kind = OPK_RDSR;
               OPC_WRSR:              kind = OPK_WRSR;
               OPC_PROG:              kind = OPK_PROG;
               OPC_SECT, OPC_SECT_B:  kind = OPK_SECT;
               OPC_BLK:               kind = OPK_BLK;
               OPC_CHIP, OPC_CHIP_B:  kind = OPK_CHIP;
               default:               kind = OPK_NONE;
            endcase
         end
      end else begin : g_primary
         always_comb begin
            unique case (cmd_opcode)
               OPC_WREN: kind = OPK_WREN;
               OPC_WRDI: kind = OPK_WRDI;
               OPC_RDSR: kind = OPK_RDSR;
               OPC_WRSR: kind = OPK_WRSR;
               OPC_PROG: kind = OPK_PROG;
               OPC_SECT: kind = OPK_SECT;
               OPC_BLK:  kind = OPK_BLK;
               OPC_CHIP: kind = OPK_CHIP;
               default:  kind = OPK_NONE;
            endcase
         end
      end
   endgenerate

   always_comb begin
      live      = cmd_done && !wip;
      is_write  = (kind == OPK_WRSR) || (kind == OPK_PROG) || (kind == OPK_SECT) ||
                  (kind == OPK_BLK)  || (kind == OPK_CHIP);
      byte_ok   = (cmd_clk_count & BYTE_LSB_MASK) == '0;
      sr_ok     = !(srwd && !wp_n);
      chip_ok   = (bp == 3'b000);
      set_wel   = live && (kind == OPK_WREN);
      clr_wel   = live && (kind == OPK_WRDI);
      launch    = live && is_write && wel && byte_ok &&
                  ((kind != OPK_WRSR) || sr_ok) &&
                  ((kind != OPK_CHIP) || chip_ok);
      wrsr_load = launch && (kind == OPK_WRSR);
   end

endmodule

// File: rtl/sfsc_busy_timer.sv
module sfsc_busy_timer
   import sfsc_pkg::*;
#(
   parameter int T_WRSR = 6,
   parameter int T_PROG = 12,
   parameter int T_SECT = 16,
   parameter int T_BLK  = 20,
   parameter int T_CHIP = 24
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     launch,
   input  op_kind_e kind,
   output logic     wip,
   output logic     done
);

   localparam int T_MAX_A = (T_WRSR > T_PROG) ? T_WRSR : T_PROG;
   localparam int T_MAX_B = (T_SECT > T_BLK) ? T_SECT : T_BLK;
   localparam int T_MAX_C = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
   localparam int T_MAX   = (T_MAX_C > T_CHIP) ? T_MAX_C : T_CHIP;
   localparam int BUSY_W  = $clog2(T_MAX + 1);

   logic [BUSY_W-1:0] cnt_q, load_val;

   always_comb begin
      unique case (kind)
         OPK_WRSR: load_val = BUSY_W'(T_WRSR);
         OPK_PROG: load_val = BUSY_W'(T_PROG);
         OPK_SECT: load_val = BUSY_W'(T_SECT);
         OPK_BLK:  load_val = BUSY_W'(T_BLK);
         OPK_CHIP: load_val = BUSY_W'(T_CHIP);
         default:  load_val = BUSY_W'(1);
      endcase
   end

   assign done = wip && (cnt_q == BUSY_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wip   <= 1'b0;
         cnt_q <= '0;
      end else if (launch) begin
         wip   <= 1'b1;
         cnt_q <= load_val;
      end else if (done) begin
         wip   <= 1'b0;
         cnt_q <= '0;
      end else if (wip) begin
         cnt_q <= cnt_q - BUSY_W'(1);
      end
   end

endmodule

// File: rtl/sfsc_status_reg.sv
module sfsc_status_reg
   import sfsc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_wel,
   input  logic       clr_wel,
   input  logic       done,
   input  logic       wrsr_load,
   input  logic [7:0] wdata,
   output logic       wel,
   output logic [7:0] prot_bits
);

   logic [7:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wel  <= 1'b0;
         sr_q <= '0;
      end else begin
         if (done)         wel <= 1'b0;
         else if (set_wel) wel <= 1'b1;
         else if (clr_wel) wel <= 1'b0;
         if (wrsr_load)
            sr_q <= (sr_q & ~SR_WMASK) | (wdata & SR_WMASK);
      end
   end

   assign prot_bits = sr_q & SR_WMASK;

endmodule

// File: rtl/sflash_status_ctrl.sv
module sflash_status_ctrl
   import sfsc_pkg::*;
#(
   parameter int CNT_W    = 12,
   parameter bit ALIAS_EN = 1'b1,
   parameter int T_WRSR   = 6,
   parameter int T_PROG   = 12,
   parameter int T_SECT   = 16,
   parameter int T_BLK    = 20,
   parameter int T_CHIP   = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_done,
   input  logic [7:0]       cmd_opcode,
   input  logic [CNT_W-1:0] cmd_clk_count,
   input  logic [7:0]       cmd_wdata,
   input  logic             wp_n,
   output logic [7:0]       status_byte,
   output logic             busy,
   output logic             launch
);

   generate
      if (CNT_W < 4) begin : g_bad_cnt
         $error("CNT_W must be at least 4");
      end
      if (T_WRSR < 1 || T_PROG < 1 || T_SECT < 1 || T_BLK < 1 || T_CHIP < 1) begin : g_bad_t
         $error("every busy time must be at least one cycle");
      end
   endgenerate

   op_kind_e   kind;
   logic       set_wel, clr_wel, wrsr_load, done, wel, wip;
   logic [7:0] prot_bits;

   sfsc_decode #(.CNT_W(CNT_W), .ALIAS_EN(ALIAS_EN)) u_dec (
      .cmd_done      (cmd_done),
      .cmd_opcode    (cmd_opcode),
      .cmd_clk_count (cmd_clk_count),
      .wp_n          (wp_n),
      .wel           (wel),
      .wip           (wip),
      .srwd          (prot_bits[7]),
      .bp            (prot_bits[4:2]),
      .kind          (kind),
      .set_wel       (set_wel),
      .clr_wel       (clr_wel),
      .launch        (launch),
      .wrsr_load     (wrsr_load)
   );

   sfsc_busy_timer #(
      .T_WRSR(T_WRSR), .T_PROG(T_PROG), .T_SECT(T_SECT),
      .T_BLK(T_BLK), .T_CHIP(T_CHIP)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .launch (launch),
      .kind   (kind),
      .wip    (wip),
      .done   (done)
   );

   sfsc_status_reg u_sr (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_wel   (set_wel),
      .clr_wel   (clr_wel),
      .done      (done),
      .wrsr_load (wrsr_load),
      .wdata     (cmd_wdata),
      .wel       (wel),
      .prot_bits (prot_bits)
   );

   assign busy        = wip;
   assign status_byte = prot_bits | {6'b0, wel, wip};

endmodule

// File: rtl/sfsc_checker.sv
module sfsc_checker #(
   parameter int CNT_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_done,
   input logic [7:0]       cmd_opcode,
   input logic [CNT_W-1:0] cmd_clk_count,
   input logic             wp_n,
   input logic [7:0]       status_byte,
   input logic             busy,
   input logic             launch
);

   localparam logic [CNT_W-1:0] LSB3 = CNT_W'(7);

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (status_byte == 8'h00) && !busy);

   assert_wel_needed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> status_byte[1]);

   assert_whole_bytes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      launch |-> ((cmd_clk_count & LSB3) == '0));

   assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[6:5] == 2'b00);

   assert_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_done && cmd_opcode == 8'h01 && status_byte[7] && !wp_n) |=> $stable(status_byte[7:2]));

   assert_chip_guard_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && (cmd_opcode == 8'hC7 || cmd_opcode == 8'h60)) |-> status_byte[4:2] == 3'b000);

   assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> busy);

   assert_wel_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !status_byte[1]);

   assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !launch);

   assert_wip_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
      status_byte[0] == busy);

endmodule

bind sflash_status_ctrl sfsc_checker #(.CNT_W(CNT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_done      (cmd_done),
   .cmd_opcode    (cmd_opcode),
   .cmd_clk_count (cmd_clk_count),
   .wp_n          (wp_n),
   .status_byte   (status_byte),
   .busy          (busy),
   .launch        (launch)
);

// File: tb/tb_sflash_status_ctrl.sv
`timescale 1ns/1ps
module tb_sflash_status_ctrl;

   localparam int CW = 12;
   localparam int TW = 6, TP = 12, TS = 16, TB = 20, TC = 24;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_done = 1'b0;
   logic [7:0]    cmd_opcode = '0;
   logic [CW-1:0] cmd_clk_count = '0;
   logic [7:0]    cmd_wdata = '0;
   logic          wp_n = 1'b1;
   logic [7:0]    status_byte;
   logic          busy, launch;

   int n_tests = 0;
   int n_fail  = 0;

   always #4 clk = ~clk;

   sflash_status_ctrl #(
      .CNT_W(CW), .ALIAS_EN(1'b1), .T_WRSR(TW), .T_PROG(TP),
      .T_SECT(TS), .T_BLK(TB), .T_CHIP(TC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd_done(cmd_done), .cmd_opcode(cmd_opcode),
      .cmd_clk_count(cmd_clk_count), .cmd_wdata(cmd_wdata), .wp_n(wp_n),
      .status_byte(status_byte), .busy(busy), .launch(launch)
   );

   typedef struct packed {
      logic [7:0]    op;
      logic [CW-1:0] cnt;
      logic [7:0]    data;
      logic          wp;
      logic [7:0]    now;
      logic [7:0]    cyc;
      logic [7:0]    after;
      logic [7:0]    req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{8'h01, 12'd16, 8'hFF, 1'b1, 8'h00, 8'd0,  8'h00, 8'd3},  // R3 status write, latch clear
      '{8'h06, 12'd8,  8'h00, 1'b1, 8'h02, 8'd0,  8'h02, 8'd2},  // R2 set latch
      '{8'h04, 12'd8,  8'h00, 1'b1, 8'h00, 8'd0,  8'h00, 8'd2},  // R2 clear latch
      '{8'h06, 12'd8,  8'h00, 1'b1, 8'h02, 8'd0,  8'h02, 8'd2},
      '{8'h01, 12'd15, 8'hFF, 1'b1, 8'h02, 8'd0,  8'h02, 8'd4},  // R4 odd clock count
      '{8'h01, 12'd16, 8'hFF, 1'b1, 8'h9F, 8'd6,  8'h9C, 8'd5},  // R5 masked write
      '{8'h06, 12'd8,  8'h00, 1'b1, 8'h9E, 8'd0,  8'h9E, 8'd2},
      '{8'h01, 12'd16, 8'h00, 1'b0, 8'h9E, 8'd0,  8'h9E, 8'd6},  // R6 locked by pin
      '{8'h01, 12'd16, 8'h60, 1'b1, 8'h03, 8'd6,  8'h00, 8'd6},  // R6 pin high unlocks, R5 bits 5,6
      '{8'h06, 12'd8,  8'h00, 1'b1, 8'h02, 8'd0,  8'h02, 8'd2},
      '{8'h02, 12'd40, 8'h00, 1'b1, 8'h03, 8'd12, 8'h00, 8'd8},  // R8 program window
      '{8'h06, 12'd8,  8'h00, 1'b0, 8'h02, 8'd0,  8'h02, 8'd2},
      '{8'h20, 12'd32, 8'h00, 1'b0, 8'h03, 8'd16, 8'h00, 8'd8},  // R8 sector window
      '{8'h02, 12'd40, 8'h00, 1'b1, 8'h00, 8'd0,  8'h00, 8'd3},  // R3 program, latch clear
      '{8'h06, 12'd8,  8'h00, 1'b1, 8'h02, 8'd0,  8'h02, 8'd2},
      '{8'hD8, 12'd32, 8'h00, 1'b1, 8'h03, 8'd20, 8'h00, 8'd8}   // R8 block window
   };

   task automatic chk(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %02h expected %02h", req, what, act, exp);
      end
   endtask

   // drive one command; returns at the falling edge after the capturing edge
   task automatic issue(input logic [7:0] op, input logic [CW-1:0] cnt,
                        input logic [7:0] data, input logic wp);
      @(negedge clk);
      cmd_opcode = op; cmd_clk_count = cnt; cmd_wdata = data; wp_n = wp; cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
   endtask

   task automatic wait_idle(input int limit);
      for (int k = 0; k < limit && busy; k++) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(1, "reset status", status_byte, 8'h00);   // R1
      chk(1, "reset busy", {7'b0, busy}, 8'h00);

      for (int i = 0; i < NV; i++) begin
         issue(VECS[i].op, VECS[i].cnt, VECS[i].data, VECS[i].wp);
         chk(VECS[i].req, $sformatf("vec %0d status", i), status_byte, VECS[i].now);
         chk(10, $sformatf("vec %0d busy mirror", i), {7'b0, busy}, {7'b0, VECS[i].now[0]}); // R10
         if (VECS[i].cyc != 0) begin
            repeat (int'(VECS[i].cyc) - 1) @(negedge clk);
            chk(8, $sformatf("vec %0d busy at last cycle", i), {7'b0, busy}, 8'h01);
            @(negedge clk);
            chk(8, $sformatf("vec %0d after window", i), status_byte, VECS[i].after);
         end
      end

      // R7 chip erase blocked by nonzero protect bits
      issue(8'h06, 12'd8, 8'h00, 1'b1);
      issue(8'h01, 12'd16, 8'h04, 1'b1);
      wait_idle(100);
      chk(5, "bp0 set", status_byte, 8'h04);
      issue(8'h06, 12'd8, 8'h00, 1'b1);
      issue(8'hC7, 12'd8, 8'h00, 1'b1);
      chk(7, "C7 refused", status_byte, 8'h06);
      issue(8'h60, 12'd8, 8'h00, 1'b1);
      chk(7, "60 refused", status_byte, 8'h06);
      issue(8'h01, 12'd16, 8'h00, 1'b1);
      wait_idle(100);
      chk(5, "bp cleared", status_byte, 8'h00);
      issue(8'h06, 12'd8, 8'h00, 1'b1);
      issue(8'h60, 12'd8, 8'h00, 1'b1);
      chk(7, "60 accepted", status_byte, 8'h03);

      // R9 commands ignored while busy
      issue(8'h04, 12'd8, 8'h00, 1'b1);
      chk(9, "WRDI while busy", status_byte, 8'h03);
      issue(8'h01, 12'd16, 8'hFF, 1'b1);
      chk(9, "WRSR while busy", status_byte, 8'h03);
      issue(8'h05, 12'd16, 8'h00, 1'b1);
      chk(9, "RDSR while busy", status_byte, 8'h03);
      wait_idle(100);
      chk(8, "chip erase done", status_byte, 8'h00);
      issue(8'h05, 12'd16, 8'h00, 1'b1);
      chk(9, "RDSR idle no effect", status_byte, 8'h00);

      // R1 reset in mid busy window
      issue(8'h06, 12'd8, 8'h00, 1'b1);
      issue(8'h02, 12'd8, 8'h00, 1'b1);
      chk(8, "program busy", status_byte, 8'h03);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      chk(1, "mid-busy reset", status_byte, 8'h00);
      chk(1, "mid-busy reset busy", {7'b0, busy}, 8'h00);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule